// File: doc/BRIEF.md
# RTC Control, Prescaler Stop and Interrupt Logic

This block holds the two control and status bytes of a real-time clock and produces its active-low interrupt pin. A host reaches the bytes through a plain register port: an address, a write byte and a write strobe. Every strobe is taken in the cycle it is raised, with no back-pressure and no wait state. Read data is a combinational function of the address and the stored state. Alarm and timer events arrive as one-cycle strobes from neighbouring logic. Each one latches a flag that stays set until the host clears it. The flags are gated by separate interrupt enables, and a mode bit chooses between a level timer interrupt and a pulse of a fixed tick count for each timer event.

A stop bit holds the seconds prescaler in asynchronous clear, which freezes the time base. The clock output keeps toggling on every oscillator tick while the prescaler is stopped. A test bit moves the prescaler onto an external tick strobe in place of the oscillator tick. A power-on override bit is stored and driven out to the neighbouring reset logic.

Top module: `rtc_ctrl_irq`

## Requirements
- R1: After reset, address 00h reads 08h, address 01h reads 00h, irq_no is 1, clkout_o is 0, test_mode_o is 0 and por_ovr_o is 1.
- R2: Control byte 0 sits at address 00h. Bit 7 is test mode (driven on test_mode_o), bit 5 is stop and bit 3 is the power-on override (driven on por_ovr_o). Bits 6, 4 and 2:0 always read 0. At any address other than 00h and 01h, a write changes nothing and a read returns 0.
- R3: Control byte 1 sits at address 01h. Bit 4 is the pulse-mode select, bit 1 is the alarm interrupt enable and bit 0 is the timer interrupt enable. All three are written directly. Bits 7:5 always read 0.
- R4: The alarm flag (address 01h bit 3) and the timer flag (address 01h bit 2) are set by alarm_evt_i and timer_evt_i. A flag stays set until a write to 01h with 0 in its bit position. Writing 1 to a flag leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R5: With the mode bit at 0 and the timer enable at 1, the timer path drives irq_no low exactly while the timer flag is set.
- R6: With the mode bit at 1 and the timer enable at 1, each timer event drives irq_no low for PULSE_TICKS tick_i strobes. A new event reloads the full count. The latched timer flag does not hold irq_no low in this mode.
- R7: While the alarm flag and the alarm enable are both 1, irq_no is 0 in either mode. irq_no is low when the alarm path or the timer path is active.
- R8: irq_no returns to 1 in the cycle after the write that clears the last active flag or enable.
- R9: While stop is 1, the prescaler is held at zero and sec_tick_o stays 0. After stop is cleared, the first sec_tick_o comes with the 2^PRESC_W-th advance.
- R10: clkout_o toggles on every tick_i strobe, whatever the state of stop or test mode.
- R11: With test mode at 1, the prescaler advances on ext_tick_i and ignores tick_i. With test mode at 0, it advances on tick_i and ignores ext_tick_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wdata_i | input | 8 | Write byte |
| we_i | input | 1 | Write strobe, one byte per cycle |
| rdata_o | output | 8 | Read byte at addr_i |
| alarm_evt_i | input | 1 | One-cycle alarm match strobe |
| timer_evt_i | input | 1 | One-cycle timer expiry strobe |
| tick_i | input | 1 | Oscillator tick strobe |
| ext_tick_i | input | 1 | External test tick strobe |
| irq_no | output | 1 | Interrupt, active low |
| clkout_o | output | 1 | Clock output, toggles on each tick_i |
| sec_tick_o | output | 1 | One-cycle strobe when the prescaler wraps |
| test_mode_o | output | 1 | Stored test-mode bit |
| por_ovr_o | output | 1 | Stored power-on override bit |

## Verification
The assertions assume that every strobe input, tick_i and we_i are 0 while rst_ni is low, and that the stored stop bit is the only source of the prescaler clear apart from reset. The bench drives all inputs only after the falling clock edge and holds them at 0 through reset. Random traffic keeps the stop and test bits set only part of the time, so the prescaler still reaches its wrap point. Tick and event strobes are drawn at rates that let pulses both expire and retrigger.

// File: rtl/rtc_ctrl_pkg.sv
package rtc_ctrl_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADR_CTRL1 = 0;
  localparam int unsigned ADR_CTRL2 = 1;

  // control byte 0 bit positions
  localparam int unsigned C1_TEST = 7;
  localparam int unsigned C1_STOP = 5;
  localparam int unsigned C1_POR  = 3;

  // control byte 1 bit positions
  localparam int unsigned C2_MODE = 4;
  localparam int unsigned C2_AF   = 3;
  localparam int unsigned C2_TF   = 2;
  localparam int unsigned C2_AIE  = 1;
  localparam int unsigned C2_TIE  = 0;

  typedef struct packed {
    logic test_mode;
    logic stop;
    logic por_ovr;
  } ctl1_t;

  typedef struct packed {
    logic pulse_mode;
    logic af;
    logic tf;
    logic aie;
    logic tie;
  } ctl2_t;
endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              alarm_evt_i,
  input  logic              timer_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctl1_t             ctl1_o,
  output ctl2_t             ctl2_o
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(ADR_CTRL1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(ADR_CTRL2);

  ctl1_t c1_q;
  ctl2_t c2_q;
  logic  hit1, hit2;
  logic  af_keep, tf_keep;
  logic  unused_wbit;

  assign hit1 = we_i && (addr_i == A1);
  assign hit2 = we_i && (addr_i == A2);
  assign unused_wbit = wdata_i[6];

  // a write of 0 clears a flag; a write of 1 or no write keeps it
  assign af_keep = c2_q.af && !(hit2 && !wdata_i[C2_AF]);
  assign tf_keep = c2_q.tf && !(hit2 && !wdata_i[C2_TF]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '{test_mode: 1'b0, stop: 1'b0, por_ovr: 1'b1};
      c2_q <= '0;
    end else begin
      if (hit1) begin
        c1_q.test_mode <= wdata_i[C1_TEST];
        c1_q.stop      <= wdata_i[C1_STOP];
        c1_q.por_ovr   <= wdata_i[C1_POR];
      end
      if (hit2) begin
        c2_q.pulse_mode <= wdata_i[C2_MODE];
        c2_q.aie        <= wdata_i[C2_AIE];
        c2_q.tie        <= wdata_i[C2_TIE];
      end
      c2_q.af <= alarm_evt_i || af_keep;
      c2_q.tf <= timer_evt_i || tf_keep;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A1) begin
      rdata_o[C1_TEST] = c1_q.test_mode;
      rdata_o[C1_STOP] = c1_q.stop;
      rdata_o[C1_POR]  = c1_q.por_ovr;
    end else if (addr_i == A2) begin
      rdata_o[C2_MODE] = c2_q.pulse_mode;
      rdata_o[C2_AF]   = c2_q.af;
      rdata_o[C2_TF]   = c2_q.tf;
      rdata_o[C2_AIE]  = c2_q.aie;
      rdata_o[C2_TIE]  = c2_q.tie;
    end
  end

  assign ctl1_o = c1_q;
  assign ctl2_o = c2_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic               ext_tick_i,
  input  logic               test_mode_i,
  output logic               sec_tick_o,
  output logic               clkout_o,
  output logic [PRESC_W-1:0] cnt_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic               adv;
  logic               clk_q;

  assign adv = test_mode_i ? ext_tick_i : tick_i;

  // divider chain: asynchronously cleared by reset or stop
  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  // clock output runs from the oscillator tick alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else if (tick_i) clk_q <= !clk_q;
  end

  assign sec_tick_o = adv && (cnt_q == {PRESC_W{1'b1}});
  assign clkout_o   = clk_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  timer_evt_i,
  input  ctl2_t ctl2_i,
  output logic  irq_no
);
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] pcnt_q;
  logic          pulse_on;
  logic          alarm_path;
  logic          timer_path;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else if (timer_evt_i) pcnt_q <= CW'(PULSE_TICKS);
    else if (tick_i && (pcnt_q != '0)) pcnt_q <= pcnt_q - 1'b1;
  end

  assign pulse_on   = (pcnt_q != '0);
  assign alarm_path = ctl2_i.af && ctl2_i.aie;
  assign timer_path = ctl2_i.tie && (ctl2_i.pulse_mode ? pulse_on : ctl2_i.tf);
  assign irq_no     = !(alarm_path || timer_path);
endmodule

// File: rtl/rtc_ctrl_irq.sv
module rtc_ctrl_irq
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned PRESC_W     = 15,
  parameter int unsigned PULSE_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  input  logic              alarm_evt_i,
  input  logic              timer_evt_i,
  input  logic              tick_i,
  input  logic              ext_tick_i,
  output logic              irq_no,
  output logic              clkout_o,
  output logic              sec_tick_o,
  output logic              test_mode_o,
  output logic              por_ovr_o
);
  ctl1_t              c1;
  ctl2_t              c2;
  logic               presc_clr;
  logic [PRESC_W-1:0] presc_cnt;

  rtc_ctrl_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .we_i        (we_i),
    .alarm_evt_i (alarm_evt_i),
    .timer_evt_i (timer_evt_i),
    .rdata_o     (rdata_o),
    .ctl1_o      (c1),
    .ctl2_o      (c2)
  );

  assign presc_clr = !rst_ni || c1.stop;

  rtc_prescaler #(.PRESC_W(PRESC_W)) presc_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (presc_clr),
    .tick_i      (tick_i),
    .ext_tick_i  (ext_tick_i),
    .test_mode_i (c1.test_mode),
    .sec_tick_o  (sec_tick_o),
    .clkout_o    (clkout_o),
    .cnt_o       (presc_cnt)
  );

  rtc_irq_gen #(.PULSE_TICKS(PULSE_TICKS)) irq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .timer_evt_i (timer_evt_i),
    .ctl2_i      (c2),
    .irq_no      (irq_no)
  );

  assign test_mode_o = c1.test_mode;
  assign por_ovr_o   = c1.por_ovr;
endmodule

// File: rtl/rtc_ctrl_irq_chk.sv
module rtc_ctrl_irq_chk
  import rtc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned PRESC_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [7:0]         wdata_i,
  input logic               we_i,
  input logic               alarm_evt_i,
  input logic               tick_i,
  input logic               irq_no,
  input logic               clkout_o,
  input logic               sec_tick_o,
  input logic               stop_i,
  input logic               af_i,
  input logic               tf_i,
  input logic               aie_i,
  input logic               tie_i,
  input logic               mode_i,
  input logic [PRESC_W-1:0] presc_i
);
  logic clr_af_wr;
  assign clr_af_wr = we_i && (addr_i == ADDR_W'(ADR_CTRL2)) && !wdata_i[C2_AF];

  AST_AF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(alarm_evt_i) |-> af_i); // R4
  AST_AF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(af_i) && !$past(clr_af_wr)) |-> af_i); // R4
  AST_AF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_af_wr) && !$past(alarm_evt_i)) |-> !af_i); // R4
  AST_LEVEL_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && tie_i && tf_i) |-> !irq_no); // R5
  AST_ALARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_i && aie_i) |-> !irq_no); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(af_i && aie_i) && !tie_i) |-> irq_no); // R8
  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> (presc_i == '0 && !sec_tick_o)); // R9
  AST_CLKOUT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i) |-> (clkout_o != $past(clkout_o))); // R10
endmodule

bind rtc_ctrl_irq rtc_ctrl_irq_chk #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .we_i        (we_i),
  .alarm_evt_i (alarm_evt_i),
  .tick_i      (tick_i),
  .irq_no      (irq_no),
  .clkout_o    (clkout_o),
  .sec_tick_o  (sec_tick_o),
  .stop_i      (c1.stop),
  .af_i        (c2.af),
  .tf_i        (c2.tf),
  .aie_i       (c2.aie),
  .tie_i       (c2.tie),
  .mode_i      (c2.pulse_mode),
  .presc_i     (presc_cnt)
);

// File: tb/rtc_ctrl_irq_tb_top.sv
module rtc_ctrl_irq_tb_top;
  localparam int PW   = 4;
  localparam int PT   = 4;
  localparam int PMAX = (1 << PW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 0, aev = 0, tev = 0, tk = 0, ext = 0;
  logic       irq_n, clkout, sec, test_o, por_o;

  int vecs = 0, errs = 0;
  bit done = 0;

  // reference state
  bit m_test, m_stop, m_por, m_tp, m_af, m_tf, m_aie, m_tie, m_clk;
  int m_pc, m_cnt;
  bit s_irq, s_sec;

  always #5 clk = ~clk;

  rtc_ctrl_irq #(.ADDR_W(8), .PRESC_W(PW), .PULSE_TICKS(PT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .alarm_evt_i(aev), .timer_evt_i(tev), .tick_i(tk),
    .ext_tick_i(ext), .irq_no(irq_n), .clkout_o(clkout), .sec_tick_o(sec),
    .test_mode_o(test_o), .por_ovr_o(por_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'd0) return {m_test, 1'b0, m_stop, 1'b0, m_por, 3'b000};
    if (a == 8'd1) return {3'b000, m_tp, m_af, m_tf, m_aie, m_tie};
    return 8'h00;
  endfunction

  function automatic bit exp_irq();
    return !((m_af && m_aie) || (m_tie && (m_tp ? (m_pc != 0) : m_tf)));
  endfunction

  function automatic bit exp_sec(input bit t, input bit e);
    bit adv = m_test ? e : t;
    return adv && (m_cnt == PMAX) && !m_stop;
  endfunction

  task automatic model_reset();
    m_test = 0; m_stop = 0; m_por = 1; m_tp = 0; m_af = 0; m_tf = 0;
    m_aie = 0; m_tie = 0; m_clk = 0; m_pc = 0; m_cnt = 0;
  endtask

  task automatic model_edge(input bit w, input logic [7:0] a, input logic [7:0] d,
                            input bit ae, input bit te, input bit t, input bit e);
    bit adv = m_test ? e : t;
    bit naf = ae || m_af;
    bit ntf = te || m_tf;
    if (!m_stop && adv) m_cnt = (m_cnt + 1) % (PMAX + 1);
    if (t) m_clk = !m_clk;
    if (te) m_pc = PT;
    else if (t && m_pc != 0) m_pc--;
    if (w && a == 8'd0) begin m_test = d[7]; m_stop = d[5]; m_por = d[3]; end
    if (w && a == 8'd1) begin
      m_tp = d[4]; m_aie = d[1]; m_tie = d[0];
      naf = ae || (m_af && d[3]);
      ntf = te || (m_tf && d[2]);
    end
    m_af = naf; m_tf = ntf;
    if (m_stop) m_cnt = 0;
  endtask

  // one cycle: drive after the falling edge, compare, then advance the reference
  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                      input bit ae, input bit te, input bit t, input bit e);
    @(negedge clk);
    we = w; addr = a; wdata = d; aev = ae; tev = te; tk = t; ext = e;
    #1;
    s_irq = irq_n; s_sec = sec;
    chk(a == 8'd0 ? "R2 rdata ctrl0" : (a == 8'd1 ? "R3/R4 rdata ctrl1" : "R2 rdata unmapped"),
        rdata, exp_rd(a));
    chk(m_tp ? "R6/R7 irq_no" : "R5/R7 irq_no", irq_n, exp_irq());
    chk(m_test ? "R11 sec_tick" : "R9 sec_tick", sec, exp_sec(t, e));
    chk("R10 clkout", clkout, m_clk);
    chk("R2 test_mode_o", test_o, m_test);
    chk("R2 por_ovr_o", por_o, m_por);
    @(posedge clk);
    model_edge(w, a, d, ae, te, t, e);
  endtask

  task automatic idle(input logic [7:0] a, input bit t);
    step(0, a, 8'h00, 0, 0, t, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int lowc, tks, secs;
    void'($urandom(32'h5eed_0a1b));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1;
    addr = 8'd0; #1; chk("R1 ctrl0 reset", rdata, 8'h08);
    addr = 8'd1; #1; chk("R1 ctrl1 reset", rdata, 8'h00);
    chk("R1 irq_no reset", irq_n, 1); chk("R1 clkout reset", clkout, 0);
    chk("R1 por_ovr_o reset", por_o, 1); chk("R1 test_mode_o reset", test_o, 0);

    // R2 reserved bits and unmapped addresses
    step(1, 8'd0, 8'hFF, 0, 0, 0, 0);
    idle(8'd0, 0); chk("R2 ctrl0 all-ones", rdata, 8'hA8);
    step(1, 8'd0, 8'h00, 0, 0, 0, 0);
    step(1, 8'd2, 8'hFF, 0, 0, 0, 0);
    idle(8'd2, 0); chk("R2 unmapped read", rdata, 8'h00);
    idle(8'd0, 0); chk("R2 unmapped write ignored", rdata, 8'h00);

    // R3 and R4: writing ones does not set flags
    step(1, 8'd1, 8'hFF, 0, 0, 0, 0);
    idle(8'd1, 0); chk("R3 ctrl1 all-ones", rdata, 8'h13);
    step(1, 8'd1, 8'h00, 0, 0, 0, 0);

    // R4 set, hold on write-1, clear, event beats clear
    step(0, 8'd1, 8'h00, 1, 1, 0, 0);
    step(1, 8'd1, 8'h0C, 0, 0, 0, 0);
    idle(8'd1, 0); chk("R4 flags kept on write-1", rdata, 8'h0C);
    step(1, 8'd1, 8'h00, 1, 0, 0, 0);
    idle(8'd1, 0); chk("R4 event beats clear", rdata, 8'h08);
    step(1, 8'd1, 8'h00, 0, 0, 0, 0);
    idle(8'd1, 0); chk("R4 flags cleared", rdata, 8'h00);

    // R5 level mode, R8 release after clear
    step(1, 8'd1, 8'h01, 0, 1, 0, 0);
    idle(8'd1, 0); chk("R5 level irq low", s_irq, 0);
    step(1, 8'd1, 8'h01, 0, 0, 0, 0);
    idle(8'd1, 0); chk("R8 irq released after flag clear", s_irq, 1);

    // R6 pulse width and flag not holding the line
    step(1, 8'd1, 8'h11, 0, 0, 0, 0);
    step(0, 8'd1, 8'h00, 0, 1, 0, 0);
    lowc = 0;
    for (int i = 0; i < 10; i++) begin
      idle(8'd1, 1);
      if (!s_irq) lowc++;
    end
    chk("R6 pulse length in ticks", lowc, PT);
    chk("R6 flag latched in pulse mode", rdata, 8'h15);

    // R7 alarm holds line in pulse mode, R8 release on enable clear
    step(1, 8'd1, 8'h13, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) idle(8'd1, 1);
    chk("R7 alarm holds irq in pulse mode", s_irq, 0);
    step(1, 8'd1, 8'h19, 0, 0, 0, 0);
    idle(8'd1, 0); chk("R8 irq released on enable clear", s_irq, 1);
    step(1, 8'd1, 8'h00, 0, 0, 0, 0);

    // R9 stop freezes prescaler, restart counts a full period
    for (int i = 0; i < 5; i++) idle(8'd0, 1);
    step(1, 8'd0, 8'h20, 0, 0, 1, 0);
    secs = 0;
    for (int i = 0; i < 40; i++) begin idle(8'd0, 1); if (s_sec) secs++; end
    chk("R9 no sec tick while stopped", secs, 0);
    step(1, 8'd0, 8'h00, 0, 0, 1, 0);
    tks = 0;
    for (int i = 0; i < 40; i++) begin
      idle(8'd0, 1); tks++;
      if (s_sec) break;
    end
    chk("R9 ticks to first sec after restart", tks, PMAX + 1);

    // R11 test mode uses the external strobe only
    step(1, 8'd0, 8'h80, 0, 0, 0, 0);
    secs = 0;
    for (int i = 0; i < 40; i++) begin
      step(0, 8'd0, 8'h00, 0, 0, 1, 0);
      if (s_sec) secs++;
    end
    chk("R11 tick ignored in test mode", secs, 0);
    tks = 0;
    for (int i = 0; i < 40; i++) begin
      step(0, 8'd0, 8'h00, 0, 0, 0, 1); tks++;
      if (s_sec) break;
    end
    chk("R11 ext ticks to sec", tks, PMAX + 1);
    step(1, 8'd0, 8'h00, 0, 0, 0, 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, d;
      bit w;
      a = 8'($urandom % 4);
      d = 8'($urandom);
      w = ($urandom % 5) == 0;
      if (a == 8'd0) begin
        if (($urandom % 4) != 0) d[5] = 1'b0;
        if (($urandom % 3) != 0) d[7] = 1'b0;
      end
      step(w, a, d, ($urandom % 20) == 0, ($urandom % 12) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule